// File: doc/BRIEF.md
# I2C Target Address Classifier

This block sits behind the bit engine of a local I2C target port and decides, from the 7-bit address of each transaction, where the transaction goes. There are three possible destinations. The local register file answers to the block's own device ID. The register file of a remote link partner answers to a programmable partner ID. A device behind that partner answers to a programmable downstream ID. Addresses that match nothing are refused, and the bus stays free.

When an address goes to a remote destination, the block raises a bridging request toward the link transmitter. It stretches SCL until the remote side returns its acknowledge, or until a programmable timeout expires. It then reports the ACK or NACK bit for the acknowledge slot. Remote routing is enabled only in display operation.

The local ID comes from a strap input unless software overrides it. Software configures the block through a small register write port.

Top module: `i2c_addr_router`

## Requirements
- R1: After reset, `scl_hold`, `req_valid` and `dec_done` are low, the override is off, and both remote ID registers are marked unprogrammed.
- R2: The local ID follows `strap_id` until register 0x00 is written with bit 7 set. From then on it is bits 6:0 of that write. A write with bit 7 clear returns the ID to the strap.
- R3: An address equal to the local ID produces, in the cycle after `addr_valid`, a one-cycle `dec_done` with `dec_ack`=1 and `route`=1 (local), with no stretching.
- R4: In display mode, an address equal to register 0x06 (bits 6:0) raises `scl_hold` and `req_valid` in the cycle after `addr_valid`, with `route`=2 (partner).
- R5: In display mode, an address equal to register 0x07 (bits 6:0) raises `scl_hold` and `req_valid`, with `route`=3 (downstream).
- R6: A partner or downstream register that has not been written since reset matches no address.
- R7: With `display_mode` low, addresses that equal a remote ID are not stretched and are NACKed with `route`=0.
- R8: Priority is local, then partner, then downstream.
- R9: An unmatched address gives `dec_done` with `dec_ack`=0 and `route`=0, and no stretching.
- R10: A `rsp_valid` pulse during stretching drops `scl_hold` in the next cycle. In that same cycle `dec_done` pulses, with `dec_ack` equal to `rsp_ack`.
- R11: Register 0x08 holds the timeout L, latched when a request starts. Without a response, `scl_hold` stays high for exactly L+1 cycles and ends with `dec_done` and `dec_ack`=0.
- R12: An `addr_valid` during stretching and a `rsp_valid` while idle have no effect.
- R13: `req_addr` and `req_rw` carry the captured address and direction, and stay stable for the whole of the stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_id | input | 7 | Device ID from the strap sensing |
| display_mode | input | 1 | High enables remote routing |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register offset |
| reg_wr_data | input | 8 | Register write data |
| addr_valid | input | 1 | One-cycle pulse: address byte decoded |
| addr | input | 7 | Decoded target address |
| addr_rw | input | 1 | Decoded read/write bit |
| rsp_valid | input | 1 | Remote acknowledge pulse |
| rsp_ack | input | 1 | Remote ACK (1) or NACK (0) |
| scl_hold | output | 1 | Stretch SCL |
| req_valid | output | 1 | Bridging request toward the link |
| req_addr | output | 7 | Address of the bridged transaction |
| req_rw | output | 1 | Direction of the bridged transaction |
| dec_done | output | 1 | One-cycle pulse: acknowledge bit ready |
| dec_ack | output | 1 | Acknowledge-slot value (1 = ACK) |
| route | output | 2 | 0 none, 1 local, 2 partner, 3 downstream |

## Verification
The assertions check several properties on every cycle. The release and ACK hand-over follow a response. No decision pulse appears while the clock is held. The request fields stay stable during a stretch. Non-display mode never stretches, a refused route never ACKs, and no stretch outlasts the latched timeout. Other behaviours can only be shown by the bench's scenarios, which compare the design against a behavioural model: the strap override, the effect of unprogrammed ID registers, the priority order, the exact timeout length, and the inputs that are ignored.

// File: rtl/i2c_addr_router_pkg.sv
package i2c_addr_router_pkg;
  typedef enum logic [1:0] {
    RT_NONE       = 2'd0,
    RT_LOCAL      = 2'd1,
    RT_PARTNER    = 2'd2,
    RT_DOWNSTREAM = 2'd3
  } route_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } bstate_t;
endpackage

// File: rtl/router_regs.sv
module router_regs #(
  parameter int AW          = 7,
  parameter int RA_W        = 8,
  parameter int DW          = 8,
  parameter int TO_W        = 8,
  parameter logic [RA_W-1:0] OFS_DEVID   = 8'h00,
  parameter logic [RA_W-1:0] OFS_PARTNER = 8'h06,
  parameter logic [RA_W-1:0] OFS_DSTREAM = 8'h07,
  parameter logic [RA_W-1:0] OFS_TMO     = 8'h08,
  parameter logic [TO_W-1:0] DEF_TMO     = 8'd64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   strap_id,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [AW-1:0]   local_id,
  output logic [AW-1:0]   partner_id,
  output logic            partner_vld,
  output logic [AW-1:0]   dstream_id,
  output logic            dstream_vld,
  output logic [TO_W-1:0] to_limit
);
  logic            ovr_q, ovr_d;
  logic [AW-1:0]   dev_q, dev_d;
  logic [AW-1:0]   pid_q, pid_d;
  logic            pv_q, pv_d;
  logic [AW-1:0]   did_q, did_d;
  logic            dv_q, dv_d;
  logic [TO_W-1:0] tmo_q, tmo_d;

  always_comb begin
    ovr_d = ovr_q;
    dev_d = dev_q;
    pid_d = pid_q;
    pv_d  = pv_q;
    did_d = did_q;
    dv_d  = dv_q;
    tmo_d = tmo_q;
    if (wr_en) begin
      if (wr_addr == OFS_DEVID) begin
        ovr_d = wr_data[DW-1];
        dev_d = wr_data[AW-1:0];
      end
      if (wr_addr == OFS_PARTNER) begin
        pid_d = wr_data[AW-1:0];
        pv_d  = 1'b1;
      end
      if (wr_addr == OFS_DSTREAM) begin
        did_d = wr_data[AW-1:0];
        dv_d  = 1'b1;
      end
      if (wr_addr == OFS_TMO) begin
        tmo_d = wr_data[TO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      dev_q <= '0;
      pid_q <= '0;
      pv_q  <= 1'b0;
      did_q <= '0;
      dv_q  <= 1'b0;
      tmo_q <= DEF_TMO;
    end else if (wr_en) begin
      ovr_q <= ovr_d;
      dev_q <= dev_d;
      pid_q <= pid_d;
      pv_q  <= pv_d;
      did_q <= did_d;
      dv_q  <= dv_d;
      tmo_q <= tmo_d;
    end
  end

  assign local_id    = ovr_q ? dev_q : strap_id;
  assign partner_id  = pid_q;
  assign partner_vld = pv_q;
  assign dstream_id  = did_q;
  assign dstream_vld = dv_q;
  assign to_limit    = tmo_q;
endmodule

// File: rtl/addr_match.sv
module addr_match
  import i2c_addr_router_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] addr,
  input  logic          display_mode,
  input  logic [AW-1:0] local_id,
  input  logic [AW-1:0] partner_id,
  input  logic          partner_vld,
  input  logic [AW-1:0] dstream_id,
  input  logic          dstream_vld,
  output route_t        route_o
);
  logic hit_local, hit_partner, hit_dstream;

  assign hit_local   = (addr == local_id);
  assign hit_partner = display_mode && partner_vld && (addr == partner_id);
  assign hit_dstream = display_mode && dstream_vld && (addr == dstream_id);

  always_comb begin
    if (hit_local)        route_o = RT_LOCAL;
    else if (hit_partner) route_o = RT_PARTNER;
    else if (hit_dstream) route_o = RT_DOWNSTREAM;
    else                  route_o = RT_NONE;
  end
endmodule

// File: rtl/bridge_fsm.sv
module bridge_fsm
  import i2c_addr_router_pkg::*;
#(
  parameter int AW   = 7,
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_valid,
  input  logic [AW-1:0]   addr,
  input  logic            addr_rw,
  input  route_t          route_in,
  input  logic [TO_W-1:0] lim_in,
  input  logic            rsp_valid,
  input  logic            rsp_ack,
  output logic            hold,
  output logic            done,
  output logic            ack,
  output route_t          route,
  output logic [AW-1:0]   req_addr,
  output logic            req_rw
);
  bstate_t         st_q, st_d;
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic [TO_W-1:0] lim_q, lim_d;
  logic            done_q, done_d;
  logic            ack_q, ack_d;
  route_t          rt_q, rt_d;
  logic [AW-1:0]   ra_q, ra_d;
  logic            rw_q, rw_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    done_d = 1'b0;
    ack_d  = ack_q;
    rt_d   = rt_q;
    ra_d   = ra_q;
    rw_d   = rw_q;
    unique case (st_q)
      ST_IDLE: begin
        if (addr_valid) begin
          rt_d = route_in;
          if (route_in == RT_PARTNER || route_in == RT_DOWNSTREAM) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
            lim_d = lim_in;
            ra_d  = addr;
            rw_d  = addr_rw;
          end else begin
            done_d = 1'b1;
            ack_d  = (route_in == RT_LOCAL);
          end
        end
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          ack_d  = rsp_ack;
        end else if (cnt_q == lim_q) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          ack_d  = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      lim_q  <= '0;
      done_q <= 1'b0;
      ack_q  <= 1'b0;
      rt_q   <= RT_NONE;
      ra_q   <= '0;
      rw_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      done_q <= done_d;
      ack_q  <= ack_d;
      rt_q   <= rt_d;
      ra_q   <= ra_d;
      rw_q   <= rw_d;
    end
  end

  assign hold     = (st_q == ST_WAIT);
  assign done     = done_q;
  assign ack      = ack_q;
  assign route    = rt_q;
  assign req_addr = ra_q;
  assign req_rw   = rw_q;
endmodule

// File: rtl/i2c_addr_router.sv
module i2c_addr_router
  import i2c_addr_router_pkg::*;
#(
  parameter int AW   = 7,
  parameter int RA_W = 8,
  parameter int DW   = 8,
  parameter int TO_W = 8,
  parameter logic [TO_W-1:0] DEF_TMO = 8'd64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   strap_id,
  input  logic            display_mode,
  input  logic            reg_wr_en,
  input  logic [RA_W-1:0] reg_wr_addr,
  input  logic [DW-1:0]   reg_wr_data,
  input  logic            addr_valid,
  input  logic [AW-1:0]   addr,
  input  logic            addr_rw,
  input  logic            rsp_valid,
  input  logic            rsp_ack,
  output logic            scl_hold,
  output logic            req_valid,
  output logic [AW-1:0]   req_addr,
  output logic            req_rw,
  output logic            dec_done,
  output logic            dec_ack,
  output logic [1:0]      route
);
  logic [AW-1:0]   local_id, partner_id, dstream_id;
  logic            partner_vld, dstream_vld;
  logic [TO_W-1:0] to_limit;
  route_t          cls_route, fsm_route;
  logic            hold_w;

  router_regs #(.AW(AW), .RA_W(RA_W), .DW(DW), .TO_W(TO_W), .DEF_TMO(DEF_TMO)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .local_id(local_id), .partner_id(partner_id), .partner_vld(partner_vld),
    .dstream_id(dstream_id), .dstream_vld(dstream_vld), .to_limit(to_limit)
  );

  addr_match #(.AW(AW)) u_match (
    .addr(addr), .display_mode(display_mode), .local_id(local_id),
    .partner_id(partner_id), .partner_vld(partner_vld),
    .dstream_id(dstream_id), .dstream_vld(dstream_vld), .route_o(cls_route)
  );

  bridge_fsm #(.AW(AW), .TO_W(TO_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr(addr),
    .addr_rw(addr_rw), .route_in(cls_route), .lim_in(to_limit),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .hold(hold_w),
    .done(dec_done), .ack(dec_ack), .route(fsm_route),
    .req_addr(req_addr), .req_rw(req_rw)
  );

  assign scl_hold  = hold_w;
  assign req_valid = hold_w;
  assign route     = fsm_route;
endmodule

// File: rtl/router_chk.sv
module router_chk #(
  parameter int AW   = 7,
  parameter int TO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            display_mode,
  input logic            addr_valid,
  input logic            rsp_valid,
  input logic            rsp_ack,
  input logic            scl_hold,
  input logic            dec_done,
  input logic            dec_ack,
  input logic [1:0]      route,
  input logic [AW-1:0]   req_addr,
  input logic            req_rw,
  input logic [TO_W-1:0] to_limit
);
  logic [TO_W:0]   hold_cnt;
  logic [TO_W-1:0] lim_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      lim_seen <= '0;
    end else begin
      hold_cnt <= scl_hold ? hold_cnt + 1'b1 : '0;
      if (!scl_hold) lim_seen <= to_limit;
    end
  end

  a_r10_release_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && rsp_valid |=> !scl_hold && dec_done && (dec_ack == $past(rsp_ack)));

  a_r12_no_done_while_hold: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> !dec_done);

  a_r13_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold && $past(scl_hold) |-> $stable(req_addr) && $stable(req_rw));

  a_r7_no_stretch_non_display: assert property (@(posedge clk) disable iff (!rst_n)
    !display_mode && addr_valid && !scl_hold |=> !scl_hold);

  a_r9_refused_is_nack: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done && (route == 2'd0) |-> !dec_ack);

  a_r11_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (hold_cnt <= {1'b0, lim_seen}));
endmodule

bind i2c_addr_router router_chk #(.AW(AW), .TO_W(TO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .display_mode(display_mode),
  .addr_valid(addr_valid), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
  .scl_hold(scl_hold), .dec_done(dec_done), .dec_ack(dec_ack),
  .route(route), .req_addr(req_addr), .req_rw(req_rw), .to_limit(to_limit)
);

// File: tb/i2c_addr_router_tb.sv
module i2c_addr_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] STRAP = 7'h2A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] strap_id;
  logic       display_mode, reg_wr_en, addr_valid, addr_rw, rsp_valid, rsp_ack;
  logic [7:0] reg_wr_addr, reg_wr_data;
  logic [6:0] addr;
  logic       scl_hold, req_valid, req_rw, dec_done, dec_ack;
  logic [6:0] req_addr;
  logic [1:0] route;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_router u_dut (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .display_mode(display_mode),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .addr_valid(addr_valid), .addr(addr), .addr_rw(addr_rw),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .scl_hold(scl_hold),
    .req_valid(req_valid), .req_addr(req_addr), .req_rw(req_rw),
    .dec_done(dec_done), .dec_ack(dec_ack), .route(route)
  );

  // behavioural reference model
  int m_wait, m_cnt, m_lim, m_done, m_ack, m_route, m_raddr, m_rrw;
  int m_ovr, m_dev, m_pid, m_pv, m_did, m_dv, m_tmo;

  function automatic int classify(int a);
    int lid;
    lid = m_ovr ? m_dev : int'(strap_id);
    if (a == lid) return 1;
    if (display_mode && m_pv != 0 && a == m_pid) return 2;
    if (display_mode && m_dv != 0 && a == m_did) return 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wait = 0; m_cnt = 0; m_lim = 0; m_done = 0; m_ack = 0; m_route = 0;
      m_raddr = 0; m_rrw = 0; m_ovr = 0; m_dev = 0; m_pid = 0; m_pv = 0;
      m_did = 0; m_dv = 0; m_tmo = 64;
    end else begin
      int r;
      m_done = 0;
      if (m_wait == 0) begin
        if (addr_valid) begin
          r = classify(int'(addr));
          m_route = r;
          if (r >= 2) begin
            m_wait = 1; m_cnt = 0; m_lim = m_tmo;
            m_raddr = int'(addr); m_rrw = int'(addr_rw);
          end else begin
            m_done = 1; m_ack = (r == 1);
          end
        end
      end else begin
        if (rsp_valid) begin
          m_wait = 0; m_done = 1; m_ack = int'(rsp_ack);
        end else if (m_cnt == m_lim) begin
          m_wait = 0; m_done = 1; m_ack = 0;
        end else m_cnt++;
      end
      if (reg_wr_en) begin
        case (reg_wr_addr)
          8'h00: begin m_ovr = reg_wr_data[7]; m_dev = int'(reg_wr_data[6:0]); end
          8'h06: begin m_pid = int'(reg_wr_data[6:0]); m_pv = 1; end
          8'h07: begin m_did = int'(reg_wr_data[6:0]); m_dv = 1; end
          8'h08: m_tmo = int'(reg_wr_data);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(scl_hold) == m_wait, "R4 hold", int'(scl_hold), m_wait);
      chk(int'(req_valid) == m_wait, "R5 req_valid", int'(req_valid), m_wait);
      chk(int'(dec_done) == m_done, "R10 done", int'(dec_done), m_done);
      if (m_done != 0) chk(int'(dec_ack) == m_ack, "R9 ack", int'(dec_ack), m_ack);
      chk(int'(route) == m_route, "R8 route", int'(route), m_route);
      if (m_wait != 0) begin
        chk(int'(req_addr) == m_raddr, "R13 req_addr", int'(req_addr), m_raddr);
        chk(int'(req_rw) == m_rrw, "R13 req_rw", int'(req_rw), m_rrw);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw);
    @(negedge clk); addr_valid = 1; addr = a; addr_rw = rw;
    @(negedge clk); addr_valid = 0;
  endtask

  task automatic send_rsp(input logic ab);
    @(negedge clk); rsp_valid = 1; rsp_ack = ab;
    @(negedge clk); rsp_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; strap_id = STRAP; display_mode = 1; reg_wr_en = 0;
    reg_wr_addr = 0; reg_wr_data = 0; addr_valid = 0; addr = 0; addr_rw = 0;
    rsp_valid = 0; rsp_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_hold && !req_valid && !dec_done, "R1", int'(scl_hold), 0);

    // R3 local hit on strap ID
    send_addr(STRAP, 0);
    chk(dec_done && dec_ack && route == 2'd1 && !scl_hold, "R3", int'(route), 1);

    // R6 unprogrammed registers (reset contents 0) match nothing
    send_addr(7'h00, 0);
    chk(dec_done && !dec_ack && !scl_hold, "R6", int'(scl_hold), 0);

    // R9 unmatched address
    send_addr(7'h11, 1);
    chk(dec_done && !dec_ack && route == 2'd0, "R9", int'(route), 0);

    wr(8'h06, 8'h50);
    wr(8'h07, 8'h51);

    // R4 partner hit, then R10 ACK return
    send_addr(7'h50, 0);
    chk(scl_hold && req_valid && route == 2'd2, "R4", int'(route), 2);
    repeat (3) @(negedge clk);
    send_rsp(1);
    chk(!scl_hold && dec_done && dec_ack, "R10", int'(dec_ack), 1);

    // R5 downstream hit with R13 fields, NACK response
    send_addr(7'h51, 1);
    chk(scl_hold && route == 2'd3, "R5", int'(route), 3);
    chk(req_addr == 7'h51 && req_rw, "R13", int'(req_addr), 'h51);
    send_rsp(0);
    chk(dec_done && !dec_ack, "R10", int'(dec_ack), 0);

    // R11 timeout with L = 4 gives 5 held cycles
    wr(8'h08, 8'd4);
    send_addr(7'h50, 0);
    begin
      int n = 0;
      while (scl_hold && n < 1000) begin n++; @(negedge clk); end
      chk(n == 5, "R11 length", n, 5);
      chk(dec_done && !dec_ack, "R11 nack", int'(dec_ack), 0);
    end

    // R12 addr_valid during a stretch is ignored; rsp while idle is ignored
    send_addr(7'h51, 0);
    send_addr(STRAP, 0);
    chk(scl_hold && route == 2'd3 && !dec_done, "R12 addr", int'(route), 3);
    send_rsp(1);
    send_rsp(1);
    chk(!dec_done && !scl_hold, "R12 rsp", int'(dec_done), 0);

    // R7 non-display mode refuses remote IDs
    display_mode = 0;
    send_addr(7'h50, 0);
    chk(!scl_hold && dec_done && !dec_ack && route == 2'd0, "R7", int'(scl_hold), 0);
    display_mode = 1;

    // R8 priority: local over partner, partner over downstream
    wr(8'h06, {1'b0, STRAP});
    send_addr(STRAP, 0);
    chk(route == 2'd1 && dec_ack && !scl_hold, "R8 local", int'(route), 1);
    wr(8'h06, 8'h50);
    wr(8'h07, 8'h50);
    send_addr(7'h50, 0);
    chk(route == 2'd2, "R8 partner", int'(route), 2);
    send_rsp(1);

    // R2 override of the local ID and return to the strap
    wr(8'h00, 8'h80 | 8'h33);
    send_addr(7'h33, 0);
    chk(dec_done && dec_ack && route == 2'd1, "R2 override", int'(route), 1);
    send_addr(STRAP, 0);
    chk(dec_done && !dec_ack, "R2 strap unused", int'(dec_ack), 0);
    wr(8'h00, 8'h33);
    send_addr(STRAP, 0);
    chk(dec_done && dec_ack, "R2 strap back", int'(dec_ack), 1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule